// File: doc/BRIEF.md
# Dual-Edge Multiplexed Video Input Demultiplexer

This block sits at the front of a video encoder. It takes one 8-bit input bus that runs at double speed and carries two independent 4:2:2 Cb-Y-Cr byte streams. A byte of the first stream is present at every rising edge of the bus clock, and a byte of the second stream at every falling edge. The block captures each stream on its own edge and moves the falling-edge stream back into the rising-edge domain, so both streams leave on one clock with equal latency.

Each stream has its own lane. The lane finds the four-byte timing reference codes in its stream, tracks whether it is inside active video, and assembles the Cb, Y, Cr, Y byte order into co-sited pixel words. A valid strobe marks each pixel word, which gives two pixels per four bytes, or half the byte rate. The lane also counts the pixels of each line and flags a line that does not hold exactly the nominal number. The rising-edge stream feeds the encoded (composite) output channel. The falling-edge stream feeds the baseband output channel.

Top module: `dual_edge_video_demux`

## Requirements
- R1: The byte sampled at a rising edge belongs to the encoded lane (`enc*` ports). The byte sampled at the falling edge that follows belongs to the baseband lane (`base*` ports). The two lanes are fully independent, and both lanes' outputs change only on rising edges. A byte sampled at rising edge n, or at the falling edge right after it, affects its lane's outputs just after rising edge n+2.
- R2: A timing reference code is the byte run 0xFF, 0x00, 0x00, XY, where XY has bit 7 set. Bit 6 is the field flag, bit 5 the vertical-blank flag and bit 4 the line-end flag (0 = start of active video, 1 = end of active video). Each XY byte loads bit 6 into `*Field` and bit 5 into `*Vblank`.
- R3: After a start code with the vertical-blank flag clear, data bytes arrive in the order Cb, Y0, Cr, Y1. The Cr byte produces a valid pixel (Y0, Cb, Cr) and the Y1 byte produces a valid pixel (Y1, Cb, Cr). `*Valid` is high for exactly that one cycle for each pixel.
- R4: Outside active video, the pixel outputs read Y=16, Cb=128, Cr=128 and `*Valid` is low. This holds after reset, after an end code, and after a start code until the first pixel arrives.
- R5: A start code whose vertical-blank flag is set does not start active video. The data bytes that follow it produce no valid pixel, and the outputs stay at black level.
- R6: At an end code that closes an active line, `*LineErr` goes high if the line produced any number of pixels other than 720. It stays high until the next start code that begins active video, which clears it. A line of exactly 720 pixels leaves it low. A start code with the vertical-blank flag set leaves it unchanged.
- R7: Within active video, the pixel outputs hold the last valid pixel between valid strobes, including through the preamble bytes of the end code.
- R8: A synchronous active-low reset clears the flags, the error, the pixel counter and the byte phase, and sets the outputs to black level. Data bytes that arrive after reset produce no pixel until the next start code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-speed bus clock; both edges carry data |
| rstN | input | 1 | Synchronous active-low reset |
| vidIn | input | 8 | Multiplexed video byte bus |
| encValid | output | 1 | Pixel strobe, encoded lane |
| encY | output | 8 | Luma, encoded lane |
| encCb | output | 8 | Blue-difference chroma, encoded lane |
| encCr | output | 8 | Red-difference chroma, encoded lane |
| encField | output | 1 | Latched field flag, encoded lane |
| encVblank | output | 1 | Latched vertical-blank flag, encoded lane |
| encLineErr | output | 1 | Line length error, encoded lane |
| baseValid | output | 1 | Pixel strobe, baseband lane |
| baseY | output | 8 | Luma, baseband lane |
| baseCb | output | 8 | Blue-difference chroma, baseband lane |
| baseCr | output | 8 | Red-difference chroma, baseband lane |
| baseField | output | 1 | Latched field flag, baseband lane |
| baseVblank | output | 1 | Latched vertical-blank flag, baseband lane |
| baseLineErr | output | 1 | Line length error, baseband lane |

## Verification
Every result of this block, whether a pixel, a strobe, a flag or an error, is due just after the second rising edge following the edge that sampled its byte. This is the same for both lanes, because the rising-edge byte waits one extra register while the falling-edge byte is re-registered. The bench drives one byte pair per clock cycle and computes the expected outputs for each byte index from the line layout. It compares them two cycles later, half a nanosecond after the rising edge, so capture and compare never share an edge. The reset checks start at the first edge where reset is low, since that edge clears the outputs.

// File: rtl/vdm_pkg.sv
`timescale 1ns/1ps
package vdm_pkg;

  // Per-byte decisions from lane control to lane datapath
  typedef struct packed {
    logic loadCb;      // byte is the shared Cb sample
    logic loadY0;      // byte is the first luma sample
    logic emitFirst;   // byte is Cr: first pixel complete
    logic emitSecond;  // byte is the second luma: second pixel complete
    logic startLine;   // start-of-active code accepted
    logic endLine;     // end-of-active code seen
    logic flagLoad;    // XY byte present
  } strobe_t;

endpackage

// File: rtl/vdm_ctrl.sv
`timescale 1ns/1ps
module vdm_ctrl
  import vdm_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ACTIVE_PIX = 720
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] byteIn,
  output strobe_t           stb,
  output logic              active,
  output logic              lineErr,
  output logic              field,
  output logic              vblank
);

  localparam int CNT_W = $clog2(ACTIVE_PIX * 2 + 2);
  localparam logic [DATA_W-1:0] CODE_HI = '1;
  localparam logic [DATA_W-1:0] CODE_LO = '0;
  localparam int MARK_BIT  = DATA_W - 1;
  localparam int FIELD_BIT = DATA_W - 2;
  localparam int VBLK_BIT  = DATA_W - 3;
  localparam int END_BIT   = DATA_W - 4;
  localparam logic [CNT_W-1:0] FULL_LINE = CNT_W'(ACTIVE_PIX);

  typedef enum logic [1:0] {SCAN, GOT_HI, GOT_LO1, GOT_LO2} trc_e;

  trc_e             trcState, trcNext;
  logic [1:0]       phase;
  logic [CNT_W-1:0] pixCnt;
  logic             dataByte;

  always_comb begin
    stb      = '0;
    trcNext  = trcState;
    dataByte = 1'b0;
    case (trcState)
      SCAN: begin
        if (byteIn == CODE_HI) begin
          trcNext = GOT_HI;
        end else if (active) begin
          dataByte       = 1'b1;
          stb.loadCb     = (phase == 2'd0);
          stb.loadY0     = (phase == 2'd1);
          stb.emitFirst  = (phase == 2'd2);
          stb.emitSecond = (phase == 2'd3);
        end
      end
      GOT_HI: begin
        if (byteIn == CODE_LO)      trcNext = GOT_LO1;
        else if (byteIn != CODE_HI) trcNext = SCAN;
      end
      GOT_LO1: begin
        trcNext = (byteIn == CODE_LO) ? GOT_LO2 : SCAN;
      end
      default: begin
        trcNext = SCAN;
        if (byteIn[MARK_BIT]) begin
          stb.flagLoad  = 1'b1;
          stb.startLine = !byteIn[END_BIT] && !byteIn[VBLK_BIT];
          stb.endLine   = byteIn[END_BIT];
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trcState <= SCAN;
      active   <= 1'b0;
      lineErr  <= 1'b0;
      field    <= 1'b0;
      vblank   <= 1'b0;
      phase    <= 2'd0;
      pixCnt   <= '0;
    end else begin
      trcState <= trcNext;
      if (stb.flagLoad) begin
        field  <= byteIn[FIELD_BIT];
        vblank <= byteIn[VBLK_BIT];
      end
      if (stb.startLine) begin
        active  <= 1'b1;
        phase   <= 2'd0;
        pixCnt  <= '0;
        lineErr <= 1'b0;
      end else if (stb.endLine) begin
        active <= 1'b0;
        if (active && pixCnt != FULL_LINE) lineErr <= 1'b1;
      end else if (dataByte) begin
        phase <= phase + 2'd1;
        if ((stb.emitFirst || stb.emitSecond) && pixCnt != '1)
          pixCnt <= pixCnt + 1'b1;
      end
    end
  end

  // R6: the error can only be raised by an end-of-active code
  assert_err_only_at_end_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lineErr) |-> $past(stb.endLine));

  // R6: a start of active video always leaves the error cleared
  assert_err_clear_at_start_R6: assert property (@(posedge clk) disable iff (!rstN)
    stb.startLine |=> !lineErr);

endmodule

// File: rtl/vdm_path.sv
`timescale 1ns/1ps
module vdm_path
  import vdm_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int BLACK_Y = 16,
  parameter int BLACK_C = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] byteIn,
  input  strobe_t           stb,
  output logic              validOut,
  output logic [DATA_W-1:0] yOut,
  output logic [DATA_W-1:0] cbOut,
  output logic [DATA_W-1:0] crOut
);

  localparam logic [DATA_W-1:0] LUMA_BLK   = DATA_W'(BLACK_Y);
  localparam logic [DATA_W-1:0] CHROMA_BLK = DATA_W'(BLACK_C);

  logic [DATA_W-1:0] cbHold, y0Hold, crHold;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validOut <= 1'b0;
      yOut     <= LUMA_BLK;
      cbOut    <= CHROMA_BLK;
      crOut    <= CHROMA_BLK;
      cbHold   <= CHROMA_BLK;
      y0Hold   <= LUMA_BLK;
      crHold   <= CHROMA_BLK;
    end else begin
      validOut <= stb.emitFirst || stb.emitSecond;
      if (stb.loadCb) cbHold <= byteIn;
      if (stb.loadY0) y0Hold <= byteIn;
      if (stb.emitFirst) begin
        crHold <= byteIn;
        yOut   <= y0Hold;
        cbOut  <= cbHold;
        crOut  <= byteIn;
      end
      if (stb.emitSecond) begin
        yOut  <= byteIn;
        cbOut <= cbHold;
        crOut <= crHold;
      end
      if (stb.startLine || stb.endLine) begin
        yOut  <= LUMA_BLK;
        cbOut <= CHROMA_BLK;
        crOut <= CHROMA_BLK;
      end
    end
  end

  // R4: line boundaries leave black level and no strobe
  assert_black_at_boundary_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.startLine || stb.endLine) |=>
      (!validOut && yOut == LUMA_BLK && cbOut == CHROMA_BLK && crOut == CHROMA_BLK));

  // R3: the second pixel of a pair reuses the stored chroma
  assert_pair_chroma_reuse_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.emitSecond |=> (validOut && cbOut == $past(cbHold) && crOut == $past(crHold)));

endmodule

// File: rtl/dual_edge_video_demux.sv
`timescale 1ns/1ps
module dual_edge_video_demux
  import vdm_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ACTIVE_PIX = 720,
  parameter int BLACK_Y    = 16,
  parameter int BLACK_C    = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] vidIn,
  output logic              encValid,
  output logic [DATA_W-1:0] encY,
  output logic [DATA_W-1:0] encCb,
  output logic [DATA_W-1:0] encCr,
  output logic              encField,
  output logic              encVblank,
  output logic              encLineErr,
  output logic              baseValid,
  output logic [DATA_W-1:0] baseY,
  output logic [DATA_W-1:0] baseCb,
  output logic [DATA_W-1:0] baseCr,
  output logic              baseField,
  output logic              baseVblank,
  output logic              baseLineErr
);

  localparam int LANES = 2;

  logic [DATA_W-1:0] riseCap, riseDly, fallCap, fallSync;

  // Edge capture; the rising byte waits one stage to meet the resynced falling byte
  always_ff @(posedge clk) riseCap <= vidIn;
  always_ff @(negedge clk) fallCap <= vidIn;
  always_ff @(posedge clk) begin
    riseDly  <= riseCap;
    fallSync <= fallCap;
  end

  logic [DATA_W-1:0] laneByte [LANES];
  logic              laneValid[LANES], laneActive[LANES];
  logic              laneErr  [LANES], laneField [LANES], laneVblank[LANES];
  logic [DATA_W-1:0] laneY    [LANES], laneCb    [LANES], laneCr    [LANES];

  assign laneByte[0] = riseDly;
  assign laneByte[1] = fallSync;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    strobe_t laneStb;

    vdm_ctrl #(.DATA_W(DATA_W), .ACTIVE_PIX(ACTIVE_PIX)) i_ctrl (
      .clk     (clk),
      .rstN    (rstN),
      .byteIn  (laneByte[i]),
      .stb     (laneStb),
      .active  (laneActive[i]),
      .lineErr (laneErr[i]),
      .field   (laneField[i]),
      .vblank  (laneVblank[i])
    );

    vdm_path #(.DATA_W(DATA_W), .BLACK_Y(BLACK_Y), .BLACK_C(BLACK_C)) i_path (
      .clk      (clk),
      .rstN     (rstN),
      .byteIn   (laneByte[i]),
      .stb      (laneStb),
      .validOut (laneValid[i]),
      .yOut     (laneY[i]),
      .cbOut    (laneCb[i]),
      .crOut    (laneCr[i])
    );

    // R5: a pixel strobe only follows a cycle of active video
    assert_valid_needs_active_R5: assert property (@(posedge clk) disable iff (!rstN)
      laneValid[i] |-> $past(laneActive[i]));
  end

  assign encValid    = laneValid[0];
  assign encY        = laneY[0];
  assign encCb       = laneCb[0];
  assign encCr       = laneCr[0];
  assign encField    = laneField[0];
  assign encVblank   = laneVblank[0];
  assign encLineErr  = laneErr[0];
  assign baseValid   = laneValid[1];
  assign baseY       = laneY[1];
  assign baseCb      = laneCb[1];
  assign baseCr      = laneCr[1];
  assign baseField   = laneField[1];
  assign baseVblank  = laneVblank[1];
  assign baseLineErr = laneErr[1];

endmodule

// File: tb/test_dual_edge_video_demux.sv
`timescale 1ns/1ps
module test_dual_edge_video_demux;

  logic       clk  = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] vidIn = 8'h10;

  logic       encValid, encField, encVblank, encLineErr;
  logic       baseValid, baseField, baseVblank, baseLineErr;
  logic [7:0] encY, encCb, encCr, baseY, baseCb, baseCr;

  dual_edge_video_demux i_dual_edge_video_demux (
    .clk(clk), .rstN(rstN), .vidIn(vidIn),
    .encValid(encValid), .encY(encY), .encCb(encCb), .encCr(encCr),
    .encField(encField), .encVblank(encVblank), .encLineErr(encLineErr),
    .baseValid(baseValid), .baseY(baseY), .baseCb(baseCb), .baseCr(baseCr),
    .baseField(baseField), .baseVblank(baseVblank), .baseLineErr(baseLineErr)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // Line table: pixel count (-1 = lane idle), seed, field flag, vblank flag per lane
  localparam int ROWS = 7;
  localparam int TAB_NR [ROWS] = '{720, 720, 722, 720, 720, 4, 720};
  localparam int TAB_NF [ROWS] = '{720, 718, 720, 720, 720, 6, -1};
  localparam int TAB_SR [ROWS] = '{3, 9, 21, 40, 55, 70, 88};
  localparam int TAB_SF [ROWS] = '{5, 12, 30, 44, 60, 77, 91};
  localparam bit TAB_FR [ROWS] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam bit TAB_VR [ROWS] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};
  localparam bit TAB_FF [ROWS] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
  localparam bit TAB_VF [ROWS] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};

  bit cErr[2], cF[2], cV[2];

  function automatic logic [7:0] pixByte(int q, int ph, int seed);
    int v;
    case (ph)
      0:       v = 16 + ((q * 7 + seed) % 200);
      1:       v = 16 + ((q * 22 + seed) % 200);
      2:       v = 16 + ((q * 5 + seed * 3) % 200);
      default: v = 16 + ((q * 22 + 11 + seed) % 200);
    endcase
    return 8'(v);
  endfunction

  function automatic logic [7:0] byteAt(int idx, int n, int seed, bit fl, bit vb);
    int e;
    int off;
    if (n < 0) return 8'h10;
    e = 8 + 2 * n;
    if (idx < 4)  return 8'h10;
    if (idx == 4) return 8'hFF;
    if (idx < 7)  return 8'h00;
    if (idx == 7) return {1'b1, fl, vb, 1'b0, 4'h0};
    if (idx < e) begin
      off = idx - 8;
      return pixByte(off / 4, off % 4, seed);
    end
    if (idx == e)     return 8'hFF;
    if (idx < e + 3)  return 8'h00;
    if (idx == e + 3) return {1'b1, fl, vb, 1'b1, 4'h0};
    return 8'h10;
  endfunction

  task automatic expAt(input int lane, input int idx, input int n, input int seed,
                       input bit fl, input bit vb,
                       output logic v, output logic [7:0] y, output logic [7:0] cb,
                       output logic [7:0] cr, output bit e, output bit f,
                       output bit vbo, output string tag);
    int ee, off, q, ph;
    v = 1'b0; y = 8'd16; cb = 8'd128; cr = 8'd128;
    e = cErr[lane]; f = cF[lane]; vbo = cV[lane]; tag = "R4";
    if (n < 0) begin tag = "R1"; return; end
    ee = 8 + 2 * n;
    if (idx >= 7) begin f = fl; vbo = vb; end
    if (vb) begin
      if (idx >= 7) tag = "R5";
      return;
    end
    if (idx >= 7) e = 1'b0;
    if (idx >= ee + 3) begin e = (n != 720); return; end
    if (idx < 8) return;
    if (idx < ee) begin
      off = idx - 8; q = off / 4; ph = off % 4;
      if (ph >= 2) begin
        v = 1'b1; tag = "R3";
        y = pixByte(q, (ph == 2) ? 1 : 3, seed);
        cb = pixByte(q, 0, seed); cr = pixByte(q, 2, seed);
      end else if (q > 0) begin
        tag = "R7";
        y = pixByte(q - 1, 3, seed); cb = pixByte(q - 1, 0, seed); cr = pixByte(q - 1, 2, seed);
      end
    end else if (n > 0) begin
      tag = "R7";
      q = n / 2 - 1;
      y = pixByte(q, 3, seed); cb = pixByte(q, 0, seed); cr = pixByte(q, 2, seed);
    end
  endtask

  task automatic step(input logic [7:0] r, input logic [7:0] f, input bit rst);
    @(negedge clk);
    #0.5;
    vidIn = r;
    rstN  = rst;
    @(posedge clk);
    #0.5;
    vidIn = f;
  endtask

  task automatic checkLane(input int lane, input logic v, input logic [7:0] y,
                           input logic [7:0] cb, input logic [7:0] cr, input bit e,
                           input bit f, input bit vb, input string tag);
    logic av, ae, af, avb;
    logic [7:0] ay, acb, acr;
    if (lane == 0) begin
      av = encValid; ay = encY; acb = encCb; acr = encCr;
      ae = encLineErr; af = encField; avb = encVblank;
    end else begin
      av = baseValid; ay = baseY; acb = baseCb; acr = baseCr;
      ae = baseLineErr; af = baseField; avb = baseVblank;
    end
    checks++;
    if (av !== v || ay !== y || acb !== cb || acr !== cr) begin
      errors++;
      $display("FAIL %s lane%0d pixel act v=%0b %h/%h/%h exp v=%0b %h/%h/%h",
               tag, lane, av, ay, acb, acr, v, y, cb, cr);
    end
    checks++;
    if (ae !== e) begin
      errors++;
      $display("FAIL R6 lane%0d lineErr act %0b exp %0b", lane, ae, e);
    end
    checks++;
    if (af !== f || avb !== vb) begin
      errors++;
      $display("FAIL R2 lane%0d flags act f=%0b v=%0b exp f=%0b v=%0b", lane, af, avb, f, vb);
    end
  endtask

  task automatic runLine(input int row);
    int nr, nf, len;
    logic v; logic [7:0] y, cb, cr; bit e, f, vb; string tag;
    nr = TAB_NR[row]; nf = TAB_NF[row];
    len = 8 + 2 * ((nr > nf) ? nr : ((nf > 0) ? nf : 0)) + 6;
    for (int idx = 0; idx < len + 2; idx++) begin
      step(byteAt(idx, nr, TAB_SR[row], TAB_FR[row], TAB_VR[row]),
           byteAt(idx, nf, TAB_SF[row], TAB_FF[row], TAB_VF[row]), 1'b1);
      if (idx >= 2) begin
        // R1: both lanes are due two rising edges after capture
        expAt(0, idx - 2, nr, TAB_SR[row], TAB_FR[row], TAB_VR[row], v, y, cb, cr, e, f, vb, tag);
        checkLane(0, v, y, cb, cr, e, f, vb, tag);
        expAt(1, idx - 2, nf, TAB_SF[row], TAB_FF[row], TAB_VF[row], v, y, cb, cr, e, f, vb, tag);
        checkLane(1, v, y, cb, cr, e, f, vb, tag);
      end
    end
    if (nr >= 0) begin
      cF[0] = TAB_FR[row]; cV[0] = TAB_VR[row];
      if (!TAB_VR[row]) cErr[0] = (nr != 720);
    end
    if (nf >= 0) begin
      cF[1] = TAB_FF[row]; cV[1] = TAB_VF[row];
      if (!TAB_VF[row]) cErr[1] = (nf != 720);
    end
  endtask

  initial begin
    for (int l = 0; l < 2; l++) begin cErr[l] = 1'b0; cF[l] = 1'b0; cV[l] = 1'b0; end
    // R8: reset state on both lanes
    for (int k = 0; k < 3; k++) step(8'h10, 8'h10, 1'b0);
    checkLane(0, 1'b0, 8'd16, 8'd128, 8'd128, 1'b0, 1'b0, 1'b0, "R8");
    checkLane(1, 1'b0, 8'd16, 8'd128, 8'd128, 1'b0, 1'b0, 1'b0, "R8");
    step(8'h10, 8'h10, 1'b1);

    for (int row = 0; row < ROWS; row++) runLine(row);

    // R8: reset in the middle of an active line; later data bytes are ignored
    for (int idx = 0; idx < 208; idx++) begin
      step(byteAt(idx, 720, 17, 1'b1, 1'b0), byteAt(idx, 720, 19, 1'b1, 1'b0),
           !(idx >= 100 && idx < 102));
      if (idx >= 100) begin
        checkLane(0, 1'b0, 8'd16, 8'd128, 8'd128, 1'b0, 1'b0, 1'b0, "R8");
        checkLane(1, 1'b0, 8'd16, 8'd128, 8'd128, 1'b0, 1'b0, 1'b0, "R8");
      end
    end
    for (int l = 0; l < 2; l++) begin cErr[l] = 1'b0; cF[l] = 1'b0; cV[l] = 1'b0; end
    // R8: output restarts at the next start code
    runLine(0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule